// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This block looks at one 32-bit single-precision operand and reports which of six classes it belongs to: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. Which value of the leading fraction bit marks a NaN as signaling is chosen by a mode input. The legacy convention treats that bit set as signaling. The newer convention treats it clear as signaling.

When the quiet request strobe is high and the operand is a signaling NaN, the block returns the quiet form of that NaN and raises an invalid-operation flag. In every other case the operand is returned unchanged and the flag stays low. Quieting in the newer convention sets the leading fraction bit. Quieting in the legacy convention clears that bit and, when that would leave an all-zero fraction (an infinity), sets the next fraction bit so that the result is still a NaN.

The logic is combinational. It ends in an output register that is present by default and can be left out with a parameter. The block sits next to an FPU datapath that needs operand classes and canonical NaN handling.

Top module: `fpnan_unit`

## Requirements
- R1: Exponent field (bits 30:23) zero gives class zero when the fraction (bits 22:0) is zero and class subnormal when it is nonzero. An exponent that is neither all zeros nor all ones gives class normal. `class_o` is one-hot: bit0 zero, bit1 subnormal, bit2 normal, bit3 infinity, bit4 quiet NaN, bit5 signaling NaN.
- R2: An all-ones exponent gives class infinity when the fraction is zero and a NaN class when the fraction is nonzero.
- R3: A NaN is signaling when `mode_i` XOR fraction bit 22 equals 1, and quiet otherwise. `mode_i`=0 selects the legacy convention and `mode_i`=1 selects the newer one.
- R4: With `mode_i`=1, quieting a signaling NaN sets bit 22 and leaves every other bit unchanged.
- R5: With `mode_i`=0, quieting a signaling NaN clears bit 22 and leaves bits 21:0 unchanged when they are nonzero.
- R6: With `mode_i`=0, if clearing bit 22 leaves the fraction all zero, the quieted result also has bit 21 set.
- R7: `invalid_o` is 1 exactly when `quiet_req_i` is 1 and the operand is a signaling NaN.
- R8: A quiet request on any operand that is not a signaling NaN returns the operand unchanged and leaves `invalid_o` at 0.
- R9: With `quiet_req_i` at 0, even a signaling NaN is returned unchanged and `invalid_o` stays 0. The class is still reported.
- R10: The sign bit (bit 31) of the result always equals the sign of the operand, including when quieting.
- R11: With the output register present, results appear one clock after the inputs. While `rst` is high, `class_o`, `result_o` and `invalid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_i | input | 32 | Operand to classify |
| mode_i | input | 1 | Quiet-bit convention: 0 legacy, 1 newer |
| quiet_req_i | input | 1 | Request to quiet a signaling NaN |
| class_o | output | 6 | One-hot class |
| result_o | output | 32 | Operand or its quieted form |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bench drives the same NaN patterns in both modes: only bit 22 set, only bit 21 set, all fraction bits set, and random payloads. A design that ignored the mode would report a quiet NaN as signaling in one of the two modes. A design that skipped the legacy repair would turn the bit-22-only NaN into an infinity. Negative-sign NaNs catch a quieting path that drops the sign. Strobe-off and non-signaling cases catch a flag or a fraction change that leaks through when no quieting should take place.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;
  localparam int EXP_W_DEF  = 8;
  localparam int FRAC_W_DEF = 23;
  localparam int CLS_N      = 6;
  // one-hot class positions
  localparam int CLS_ZERO = 0;
  localparam int CLS_SUB  = 1;
  localparam int CLS_NORM = 2;
  localparam int CLS_INF  = 3;
  localparam int CLS_QNAN = 4;
  localparam int CLS_SNAN = 5;
endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
  import fpnan_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              mode_i,
  output logic [CLS_N-1:0]  cls_o
);
  logic exp_zero, exp_ones, frac_zero, lead_sig;

  always_comb begin
    exp_zero  = (exp_i == '0);
    exp_ones  = (exp_i == '1);
    frac_zero = (frac_i == '0);
    lead_sig  = mode_i ^ frac_i[FRAC_W-1];
    cls_o = '0;
    cls_o[CLS_ZERO] = exp_zero & frac_zero;
    cls_o[CLS_SUB]  = exp_zero & ~frac_zero;
    cls_o[CLS_NORM] = ~exp_zero & ~exp_ones;
    cls_o[CLS_INF]  = exp_ones & frac_zero;
    cls_o[CLS_QNAN] = exp_ones & ~frac_zero & ~lead_sig;
    cls_o[CLS_SNAN] = exp_ones & ~frac_zero & lead_sig;
  end
endmodule

// File: rtl/fpnan_quiet.sv
module fpnan_quiet #(
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              mode_i,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int QB = FRAC_W - 1;
  localparam int RB = FRAC_W - 2;

  logic [FRAC_W-1:0] cleared;

  always_comb begin
    cleared     = frac_i;
    cleared[QB] = 1'b0;
    if (mode_i) begin
      frac_o     = frac_i;
      frac_o[QB] = 1'b1;
    end else begin
      frac_o = cleared;
      if (cleared == '0) frac_o[RB] = 1'b1;
    end
  end
endmodule

// File: rtl/fpnan_unit.sv
module fpnan_unit
  import fpnan_pkg::*;
#(
  parameter int EXP_W   = EXP_W_DEF,
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter bit REG_OUT = 1'b1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] opnd_i,
  input  logic              mode_i,
  input  logic              quiet_req_i,
  output logic [CLS_N-1:0]  class_o,
  output logic [WORD_W-1:0] result_o,
  output logic              invalid_o
);
  logic [EXP_W-1:0]  op_exp;
  logic [FRAC_W-1:0] op_frac, q_frac;
  logic [CLS_N-1:0]  cls_c;
  logic [WORD_W-1:0] res_c;
  logic              inv_c;

  assign op_exp  = opnd_i[WORD_W-2 -: EXP_W];
  assign op_frac = opnd_i[FRAC_W-1:0];

  fpnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .exp_i(op_exp), .frac_i(op_frac), .mode_i(mode_i), .cls_o(cls_c)
  );

  fpnan_quiet #(.FRAC_W(FRAC_W)) u_qt (
    .frac_i(op_frac), .mode_i(mode_i), .frac_o(q_frac)
  );

  always_comb begin
    inv_c = quiet_req_i & cls_c[CLS_SNAN];
    res_c = inv_c ? {opnd_i[WORD_W-1:FRAC_W], q_frac} : opnd_i;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          class_o   <= '0;
          result_o  <= '0;
          invalid_o <= 1'b0;
        end else begin
          class_o   <= cls_c;
          result_o  <= res_c;
          invalid_o <= inv_c;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign class_o    = cls_c;
      assign result_o   = res_c;
      assign invalid_o  = inv_c;
    end
  endgenerate
endmodule

// File: rtl/fpnan_chk.sv
module fpnan_chk #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] opnd_i,
  input logic              mode_i,
  input logic              quiet_req_i,
  input logic [5:0]        class_o,
  input logic [WORD_W-1:0] result_o,
  input logic              invalid_o
);
  logic              armed;
  logic [WORD_W-1:0] op_d;
  logic              mode_d, req_d;

  always_ff @(posedge clk) armed <= !rst;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
        op_d   <= opnd_i;
        mode_d <= mode_i;
        req_d  <= quiet_req_i;
      end
    end else begin : g_nodly
      assign op_d   = opnd_i;
      assign mode_d = mode_i;
      assign req_d  = quiet_req_i;
    end
  endgenerate

  // R1: exactly one class once running
  a_r1_class_onehot: assert property (@(posedge clk) disable iff (rst || !armed)
    $onehot(class_o));
  // R7: flag only on a requested signaling NaN
  a_r7_flag_cause: assert property (@(posedge clk) disable iff (rst || !armed)
    invalid_o |-> (req_d && class_o[5]));
  // R8/R9: without the flag the word passes through untouched
  a_r8_passthrough: assert property (@(posedge clk) disable iff (rst || !armed)
    !invalid_o |-> (result_o == op_d));
  // R10: sign survives
  a_r10_sign_kept: assert property (@(posedge clk) disable iff (rst || !armed)
    result_o[WORD_W-1] == op_d[WORD_W-1]);
  // R6: quieted value is still a NaN
  a_r6_still_nan: assert property (@(posedge clk) disable iff (rst || !armed)
    invalid_o |-> ((result_o[WORD_W-2 -: EXP_W] == '1) && (result_o[FRAC_W-1:0] != '0)));
  // R3: quieted value reads as quiet under the same mode
  a_r3_now_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
    invalid_o |-> ((mode_d ^ result_o[FRAC_W-1]) == 1'b0));
endmodule

bind fpnan_unit fpnan_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .opnd_i(opnd_i), .mode_i(mode_i), .quiet_req_i(quiet_req_i),
  .class_o(class_o), .result_o(result_o), .invalid_o(invalid_o)
);

// File: tb/sim_fpnan_unit.sv
module sim_fpnan_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_i = '0;
  logic        mode_i = 1'b0;
  logic        quiet_req_i = 1'b0;
  logic [5:0]  class_o;
  logic [31:0] result_o;
  logic        invalid_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [5:0] C_ZERO = 6'b000001, C_SUB = 6'b000010, C_NORM = 6'b000100,
                         C_INF = 6'b001000, C_QNAN = 6'b010000, C_SNAN = 6'b100000;

  always #2 clk = ~clk;

  fpnan_unit u0 (.clk(clk), .rst(rst), .opnd_i(opnd_i), .mode_i(mode_i),
    .quiet_req_i(quiet_req_i), .class_o(class_o), .result_o(result_o), .invalid_o(invalid_o));

  task automatic chk(input string req, input logic [5:0] ec, input logic [31:0] er, input logic ef);
    n_chk++;
    if (class_o !== ec || result_o !== er || invalid_o !== ef) begin
      n_bad++;
      $display("FAIL %s: got cls=%b res=%h inv=%b exp cls=%b res=%h inv=%b",
               req, class_o, result_o, invalid_o, ec, er, ef);
    end
  endtask

  // drive on falling edge, sample 1 ns after the capturing rising edge
  task automatic run(input logic [31:0] op, input logic m, input logic rq, input string req,
                     input logic [5:0] ec, input logic [31:0] er, input logic ef);
    @(negedge clk);
    opnd_i = op; mode_i = m; quiet_req_i = rq;
    @(posedge clk); #1;
    chk(req, ec, er, ef);
  endtask

  task automatic t_reset();
    @(negedge clk); opnd_i = 32'h7FC0_0000; quiet_req_i = 1'b1;
    @(posedge clk); #1;
    chk("R11 reset", 6'b0, 32'h0, 1'b0);
    @(negedge clk); rst = 1'b0; quiet_req_i = 1'b0;
  endtask

  task automatic t_classes();
    run(32'h0000_0000, 0, 1, "R1 +zero",   C_ZERO, 32'h0000_0000, 0);
    run(32'h8000_0000, 1, 1, "R1 -zero",   C_ZERO, 32'h8000_0000, 0);
    run(32'h0000_0001, 0, 0, "R1 subnorm", C_SUB,  32'h0000_0001, 0);
    run(32'h3F80_0000, 1, 1, "R1 normal",  C_NORM, 32'h3F80_0000, 0);
    run(32'h7F80_0000, 0, 1, "R2 +inf",    C_INF,  32'h7F80_0000, 0);
    run(32'hFF80_0000, 1, 1, "R2 -inf",    C_INF,  32'hFF80_0000, 0);
  endtask

  task automatic t_quiet_new();
    run(32'h7FA0_0000, 1, 1, "R4 bit21 only",   C_SNAN, 32'h7FE0_0000, 1);
    run(32'hFF80_0001, 1, 1, "R10 neg payload", C_SNAN, 32'hFFC0_0001, 1);
    run(32'h7FC0_0000, 1, 1, "R8 quiet bit22",  C_QNAN, 32'h7FC0_0000, 0);
    run(32'h7FFF_FFFF, 1, 1, "R3 all ones",     C_QNAN, 32'h7FFF_FFFF, 0);
  endtask

  task automatic t_quiet_legacy();
    run(32'h7FC0_0000, 0, 1, "R6 repair",      C_SNAN, 32'h7FA0_0000, 1);
    run(32'hFFC0_0000, 0, 1, "R10 neg repair", C_SNAN, 32'hFFA0_0000, 1);
    run(32'h7FFF_FFFF, 0, 1, "R5 all ones",    C_SNAN, 32'h7FBF_FFFF, 1);
    run(32'h7FA0_0000, 0, 1, "R8 bit21 quiet", C_QNAN, 32'h7FA0_0000, 0);
  endtask

  task automatic t_no_request();
    run(32'h7FC0_0000, 0, 0, "R9 legacy snan", C_SNAN, 32'h7FC0_0000, 0);
    run(32'h7F80_0005, 1, 0, "R9 new snan",    C_SNAN, 32'h7F80_0005, 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      logic [31:0] op, er;
      logic m, snan;
      logic [22:0] f;
      op = $urandom();
      op[30:23] = 8'hFF;
      if (op[22:0] == '0) op[0] = 1'b1;
      m = 1'($urandom());
      snan = m ? !op[22] : op[22];
      er = op;
      if (snan) begin
        if (m) er[22] = 1'b1;
        else begin
          f = op[22:0] & 23'h3F_FFFF;
          er[22:0] = (f == '0) ? 23'h20_0000 : f;
        end
      end
      run(op, m, 1, "R3/R4/R5/R7 random", snan ? C_SNAN : C_QNAN, er, snan);
    end
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (2) @(posedge clk);
    t_reset();
    t_classes();
    t_quiet_new();
    t_quiet_legacy();
    t_no_request();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule